// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block drives and samples a bank of general-purpose pins through a small word-addressed register port. The pad level for each pin comes from one of two places. Normally it is a software-written level register. When a pin is switched to alternate use, it comes from one of two peripheral sources, chosen by a per-pin select bit. In both cases a per-pin inversion bit is applied just before the pad. Pull-up and drive-strength settings are plain stored bits that go straight out to the pad cell.

On the input side each pin passes through a two-flop synchronizer and is then masked by its input-enable bit, so a disabled pin reads as 0. The masked level is given to peripherals directly. It is also captured in a readable value register. From the masked level four interrupt kinds are derived: rising edge, falling edge, high level and low level. Each kind has a per-pin pending bit, which is cleared by writing 1, and a per-pin enable bit. One interrupt line per pin reports whether any enabled kind is pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `pin_oe`, `pin_out`, `pin_pullup`, `pin_drive` and `irq` are all 0.
- R2: Registers sit at byte offsets in steps of 4, in this order from 0x00: input enable, output enable, pull-up, drive strength, output invert, input value, output level, then for rise, fall, high and low in turn an enable followed by a pending register (0x1C to 0x38), then alternate enable (0x3C) and alternate select (0x40). The writable registers read back the written word. Writes to the input value register are ignored. Unmapped offsets read 0.
- R3: For a pin whose alternate-enable bit is 0, `pin_out` equals the output-level bit XOR the invert bit, and `pin_oe` equals the output-enable bit.
- R4: For a pin whose alternate-enable bit is 1, the level and the enable come from `alt0_out`/`alt0_oe` when its select bit is 0 and from `alt1_out`/`alt1_oe` when it is 1. The invert bit still applies to the level.
- R5: A pin change that is set up before clock edge 1 reaches `alt_in` after edge 2 and the input value register after edge 3. Both are forced to 0 where the input-enable bit is 0.
- R6: A 0-to-1 change of the masked input sets the pin's rise pending bit at the same edge that updates the input value register.
- R7: A 1-to-0 change of the masked input sets the pin's fall pending bit at that edge.
- R8: The high pending bit sets on every cycle the masked input is 1, and the low pending bit sets on every cycle it is 0. A disabled pin counts as low.
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An event of that kind in the same cycle keeps the bit set.
- R10: `irq[i]` is 1 exactly when some kind has both its pending and its enable bit set for pin i.
- R11: `pin_pullup` and `pin_drive` present the pull-up and drive-strength registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| pin_pullup | output | 32 | Pull-up enables to the pad |
| pin_drive | output | 32 | Drive-strength bits to the pad |
| alt0_out | input | 32 | Peripheral source 0 output levels |
| alt0_oe | input | 32 | Peripheral source 0 output enables |
| alt1_out | input | 32 | Peripheral source 1 output levels |
| alt1_oe | input | 32 | Peripheral source 1 output enables |
| alt_in | output | 32 | Synchronized, enable-masked input levels for peripherals |
| irq | output | 32 | Per-pin interrupt request |

## Verification
A wrong synchronizer or masking state first shows on `alt_in` two edges after a pin change, and on the input value register one edge after that. An early or late edge therefore shows up as a one-cycle shift in those reads. A pending bit that was lost or wrongly set shows in the pending register read and on `irq` in the cycle after the faulty edge. A mis-decoded write shows either as a wrong read-back on the next access or as a pad output that is wrong from the next cycle on. The output path is combinational, so a fault in the select or invert logic is visible as soon as its inputs change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // interrupt kinds, in register order
  localparam int NUM_KINDS = 4;
  localparam int KIND_RISE = 0;
  localparam int KIND_FALL = 1;
  localparam int KIND_HIGH = 2;
  localparam int KIND_LOW  = 3;

  // word index of each register (byte offset = index * 4)
  localparam int REG_IN_EN   = 0;
  localparam int REG_OUT_EN  = 1;
  localparam int REG_PULLUP  = 2;
  localparam int REG_DRIVE   = 3;
  localparam int REG_INVERT  = 4;
  localparam int REG_IN_VAL  = 5;
  localparam int REG_OUT_LVL = 6;
  localparam int REG_ALT_EN  = 15;
  localparam int REG_ALT_SEL = 16;

  // enable/pending pairs start right after the output level register
  function automatic int ie_index(int kind);
    return 7 + 2 * kind;
  endfunction

  function automatic int ip_index(int kind);
    return 8 + 2 * kind;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] in_en,
  output logic [NUM_PINS-1:0] live_o,
  output logic [NUM_PINS-1:0] last_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);

  function automatic logic [NUM_PINS-1:0] went_up(logic [NUM_PINS-1:0] now_v,
                                                   logic [NUM_PINS-1:0] was_v);
    return now_v & ~was_v;
  endfunction

  function automatic logic [NUM_PINS-1:0] went_down(logic [NUM_PINS-1:0] now_v,
                                                     logic [NUM_PINS-1:0] was_v);
    return was_v & ~now_v;
  endfunction

  logic [NUM_PINS-1:0] stage_q [STAGES];
  logic [NUM_PINS-1:0] last_q;
  logic                past_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign live_o = stage_q[STAGES-1] & in_en;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= live_o;
  end

  assign last_o = last_q;
  assign rise_o = went_up(live_o, last_q);
  assign fall_o = went_down(live_o, last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // value register follows the masked level one edge later
  assert_value_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (last_o == $past(live_o)));

endmodule

// File: rtl/gpio_irq_kind.sv
module gpio_irq_kind #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] clear_i,
  input  logic [NUM_PINS-1:0] enable_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] hit_o
);

  function automatic logic [NUM_PINS-1:0] next_pend(logic [NUM_PINS-1:0] cur,
                                                     logic [NUM_PINS-1:0] clr,
                                                     logic [NUM_PINS-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  logic [NUM_PINS-1:0] pend_q;
  logic                past_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= next_pend(pend_q, clear_i, event_i);
  end

  assign pend_o = pend_q;
  assign hit_o  = pend_q & enable_i;

  always_ff @(posedge clk) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // an event is never lost, even under a same-cycle clear (R6, R7, R8)
  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> ((pend_q & $past(event_i)) == $past(event_i)));

  // a written one with no event empties the bit
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> ((pend_q & $past(clear_i & ~event_i)) == '0));

  // a bit only rises when an event was present
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> ((pend_q & ~$past(pend_q) & ~$past(event_i)) == '0));

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] sw_lvl,
  input  logic [NUM_PINS-1:0] sw_oe,
  input  logic [NUM_PINS-1:0] invert,
  input  logic [NUM_PINS-1:0] alt_en,
  input  logic [NUM_PINS-1:0] alt_sel,
  input  logic [NUM_PINS-1:0] alt0_out,
  input  logic [NUM_PINS-1:0] alt0_oe,
  input  logic [NUM_PINS-1:0] alt1_out,
  input  logic [NUM_PINS-1:0] alt1_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  function automatic logic pick(logic use_alt, logic sel, logic sw_v,
                                logic a0_v, logic a1_v);
    if (!use_alt) return sw_v;
    return sel ? a1_v : a0_v;
  endfunction

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic lvl;
    assign lvl        = pick(alt_en[i], alt_sel[i], sw_lvl[i], alt0_out[i], alt1_out[i]);
    assign pad_out[i] = lvl ^ invert[i];
    assign pad_oe[i]  = pick(alt_en[i], alt_sel[i], sw_oe[i], alt0_oe[i], alt1_oe[i]);
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pullup,
  output logic [NUM_PINS-1:0] pin_drive,
  input  logic [NUM_PINS-1:0] alt0_out,
  input  logic [NUM_PINS-1:0] alt0_oe,
  input  logic [NUM_PINS-1:0] alt1_out,
  input  logic [NUM_PINS-1:0] alt1_oe,
  output logic [NUM_PINS-1:0] alt_in,
  output logic [NUM_PINS-1:0] irq
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] reg_idx;
  int               reg_sel;
  logic             unused_addr_lsb;

  assign reg_idx         = bus_addr[ADDR_W-1:2];
  assign reg_sel         = int'({{(32-IDX_W){1'b0}}, reg_idx});
  assign unused_addr_lsb = ^bus_addr[1:0];

  // configuration and level registers
  logic [NUM_PINS-1:0] in_en_q, out_en_q, pullup_q, drive_q, invert_q;
  logic [NUM_PINS-1:0] out_lvl_q, alt_en_q, alt_sel_q;
  logic [NUM_PINS-1:0] ie_q [NUM_KINDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      pullup_q  <= '0;
      drive_q   <= '0;
      invert_q  <= '0;
      out_lvl_q <= '0;
      alt_en_q  <= '0;
      alt_sel_q <= '0;
      for (int k = 0; k < NUM_KINDS; k++) ie_q[k] <= '0;
    end else if (bus_we) begin
      case (reg_sel)
        REG_IN_EN:   in_en_q   <= bus_wdata;
        REG_OUT_EN:  out_en_q  <= bus_wdata;
        REG_PULLUP:  pullup_q  <= bus_wdata;
        REG_DRIVE:   drive_q   <= bus_wdata;
        REG_INVERT:  invert_q  <= bus_wdata;
        REG_OUT_LVL: out_lvl_q <= bus_wdata;
        REG_ALT_EN:  alt_en_q  <= bus_wdata;
        REG_ALT_SEL: alt_sel_q <= bus_wdata;
        default: ;
      endcase
      for (int k = 0; k < NUM_KINDS; k++)
        if (reg_sel == ie_index(k)) ie_q[k] <= bus_wdata;
    end
  end

  // input side
  logic [NUM_PINS-1:0] live, last, rise_ev, fall_ev;

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .in_en  (in_en_q),
    .live_o (live),
    .last_o (last),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  assign alt_in = live;

  // interrupt kinds
  logic [NUM_PINS-1:0] kind_ev   [NUM_KINDS];
  logic [NUM_PINS-1:0] kind_clr  [NUM_KINDS];
  logic [NUM_PINS-1:0] kind_pend [NUM_KINDS];
  logic [NUM_PINS-1:0] kind_hit  [NUM_KINDS];

  assign kind_ev[KIND_RISE] = rise_ev;
  assign kind_ev[KIND_FALL] = fall_ev;
  assign kind_ev[KIND_HIGH] = live;
  assign kind_ev[KIND_LOW]  = ~live;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign kind_clr[k] = (bus_we && reg_sel == ip_index(k)) ? bus_wdata : '0;

    gpio_irq_kind #(.NUM_PINS(NUM_PINS)) u_kind (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (kind_ev[k]),
      .clear_i  (kind_clr[k]),
      .enable_i (ie_q[k]),
      .pend_o   (kind_pend[k]),
      .hit_o    (kind_hit[k])
    );
  end

  always_comb begin
    irq = '0;
    for (int k = 0; k < NUM_KINDS; k++) irq = irq | kind_hit[k];
  end

  // output side
  gpio_out_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .sw_lvl   (out_lvl_q),
    .sw_oe    (out_en_q),
    .invert   (invert_q),
    .alt_en   (alt_en_q),
    .alt_sel  (alt_sel_q),
    .alt0_out (alt0_out),
    .alt0_oe  (alt0_oe),
    .alt1_out (alt1_out),
    .alt1_oe  (alt1_oe),
    .pad_out  (pin_out),
    .pad_oe   (pin_oe)
  );

  assign pin_pullup = pullup_q;
  assign pin_drive  = drive_q;

  // read port
  always_comb begin
    bus_rdata = '0;
    case (reg_sel)
      REG_IN_EN:   bus_rdata = in_en_q;
      REG_OUT_EN:  bus_rdata = out_en_q;
      REG_PULLUP:  bus_rdata = pullup_q;
      REG_DRIVE:   bus_rdata = drive_q;
      REG_INVERT:  bus_rdata = invert_q;
      REG_IN_VAL:  bus_rdata = last;
      REG_OUT_LVL: bus_rdata = out_lvl_q;
      REG_ALT_EN:  bus_rdata = alt_en_q;
      REG_ALT_SEL: bus_rdata = alt_sel_q;
      default: begin
        for (int k = 0; k < NUM_KINDS; k++) begin
          if (reg_sel == ie_index(k)) bus_rdata = ie_q[k];
          if (reg_sel == ip_index(k)) bus_rdata = kind_pend[k];
        end
      end
    endcase
  end

  logic past_valid;
  always_ff @(posedge clk) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  assert_out_lvl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(bus_we && reg_sel == REG_OUT_LVL)) |->
      (out_lvl_q == $past(bus_wdata)));

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(ie_q[KIND_RISE] | ie_q[KIND_FALL] | ie_q[KIND_HIGH] | ie_q[KIND_LOW])) == '0);

  assert_masked_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_in & ~in_en_q) == '0);

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pin_pullup, pin_drive, alt_in, irq;
  logic [N-1:0] alt0_out = '0, alt0_oe = '0, alt1_out = '0, alt1_oe = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
    .pin_drive(pin_drive), .alt0_out(alt0_out), .alt0_oe(alt0_oe),
    .alt1_out(alt1_out), .alt1_oe(alt1_oe), .alt_in(alt_in), .irq(irq)
  );

  // byte offsets from R2
  localparam int O_IN_EN = 'h00, O_OUT_EN = 'h04, O_PULL = 'h08, O_DRV = 'h0C;
  localparam int O_INV = 'h10, O_IN_VAL = 'h14, O_OUT_LVL = 'h18;
  localparam int O_RISE_IE = 'h1C, O_RISE_IP = 'h20, O_FALL_IE = 'h24, O_FALL_IP = 'h28;
  localparam int O_HIGH_IE = 'h2C, O_HIGH_IP = 'h30, O_LOW_IE = 'h34, O_LOW_IP = 'h38;
  localparam int O_ALT_EN = 'h3C, O_ALT_SEL = 'h40;

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; pin_in = '0;
    alt0_out = '0; alt0_oe = '0; alt1_out = '0; alt1_oe = '0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int off, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = 8'(off); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int off, output logic [N-1:0] d);
    bus_addr = 8'(off);
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    do_reset();
    @(negedge clk);
    for (int o = 0; o <= 'h40; o += 4) begin
      if (o == O_LOW_IP) continue; // low level pends once out of reset (R8)
      rd(o, v);
      check("R1 register zero", v, '0);
    end
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 pullup", pin_pullup, '0);
    check("R1 drive", pin_drive, '0);
    check("R1 irq", irq, '0);
  endtask

  task automatic t_regs();
    logic [N-1:0] v;
    int offs[12] = '{O_IN_EN, O_OUT_EN, O_PULL, O_DRV, O_INV, O_OUT_LVL,
                     O_RISE_IE, O_FALL_IE, O_HIGH_IE, O_LOW_IE, O_ALT_EN, O_ALT_SEL};
    do_reset();
    for (int i = 0; i < 12; i++) wr(offs[i], 32'h1000_0001 * (i + 1) ^ 32'hA5A5_0000);
    for (int i = 0; i < 12; i++) begin
      rd(offs[i], v);
      check("R2 readback", v, 32'h1000_0001 * (i + 1) ^ 32'hA5A5_0000);
    end
    wr(O_IN_VAL, 32'hFFFF_FFFF);
    rd(O_IN_VAL, v);
    check("R2 input value ignores writes", v, '0);
    rd('h44, v);
    check("R2 unmapped reads zero", v, '0);
  endtask

  task automatic t_outpath();
    do_reset();
    wr(O_OUT_LVL, 32'h1234_5678);
    wr(O_OUT_EN, 32'hFFFF_0000);
    wr(O_INV, 32'h0000_00FF);
    #1;
    check("R3 pin_out with invert", pin_out, 32'h1234_5687);
    check("R3 pin_oe", pin_oe, 32'hFFFF_0000);
  endtask

  task automatic t_alt();
    logic [N-1:0] eo, ee;
    do_reset();
    wr(O_OUT_LVL, 32'h1234_5678);
    wr(O_OUT_EN, 32'hFF00_0000);
    wr(O_INV, 32'h0000_00FF);
    alt0_out = 32'hAAAA_AAAA; alt0_oe = 32'h0F0F_0F0F;
    alt1_out = 32'h5555_5555; alt1_oe = 32'hF0F0_F0F0;
    wr(O_ALT_EN, 32'h0000_FFFF);
    wr(O_ALT_SEL, 32'h0000_00FF);
    #1;
    for (int i = 0; i < N; i++) begin
      if (i < 8)       begin eo[i] = alt1_out[i] ^ 1'b1; ee[i] = alt1_oe[i]; end
      else if (i < 16) begin eo[i] = alt0_out[i];        ee[i] = alt0_oe[i]; end
      else begin eo[i] = 32'h1234_5678 >> i; ee[i] = (i >= 24); end
    end
    check("R4 alternate level", pin_out, eo);
    check("R4 alternate enable", pin_oe, ee);
  endtask

  task automatic t_pad_cfg();
    do_reset();
    wr(O_PULL, 32'hC0FF_EE00);
    wr(O_DRV, 32'h0BAD_F00D);
    #1;
    check("R11 pullup", pin_pullup, 32'hC0FF_EE00);
    check("R11 drive", pin_drive, 32'h0BAD_F00D);
  endtask

  task automatic t_input();
    logic [N-1:0] v;
    do_reset();
    wr(O_IN_EN, 32'hFFFF_FFFF);
    pin_in = 32'h0000_00A5;
    tick(2);
    check("R5 alt_in after two edges", alt_in, 32'h0000_00A5);
    rd(O_IN_VAL, v);
    check("R5 value not yet updated", v, '0);
    tick(1);
    rd(O_IN_VAL, v);
    check("R5 value after three edges", v, 32'h0000_00A5);
    wr(O_IN_EN, 32'h0000_000F);
    tick(2);
    rd(O_IN_VAL, v);
    check("R5 masked value", v, 32'h0000_0005);
    check("R5 masked alt_in", alt_in, 32'h0000_0005);
  endtask

  task automatic t_edges();
    logic [N-1:0] v;
    do_reset();
    wr(O_IN_EN, 32'hFFFF_FFFF);
    tick(3);
    wr(O_RISE_IP, 32'hFFFF_FFFF);
    wr(O_FALL_IP, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0002;
    tick(2);
    rd(O_RISE_IP, v);
    check("R6 rise not before value edge", v, '0);
    tick(1);
    rd(O_RISE_IP, v);
    check("R6 rise pending", v, 32'h0000_0002);
    rd(O_FALL_IP, v);
    check("R7 no fall on rise", v, '0);
    pin_in = '0;
    tick(3);
    rd(O_FALL_IP, v);
    check("R7 fall pending", v, 32'h0000_0002);
  endtask

  task automatic t_levels();
    logic [N-1:0] v;
    do_reset();
    wr(O_IN_EN, 32'hFFFF_FFFF);
    pin_in = 32'h0000_FF00;
    tick(4);
    wr(O_HIGH_IP, 32'hFFFF_FFFF);
    wr(O_LOW_IP, 32'hFFFF_FFFF);
    rd(O_HIGH_IP, v);
    check("R8 high follows level", v, 32'h0000_FF00);
    rd(O_LOW_IP, v);
    check("R8 low follows level", v, 32'hFFFF_00FF);
    wr(O_IN_EN, 32'h0);
    tick(3);
    wr(O_HIGH_IP, 32'hFFFF_FFFF);
    wr(O_LOW_IP, 32'hFFFF_FFFF);
    rd(O_HIGH_IP, v);
    check("R8 disabled pins not high", v, '0);
    rd(O_LOW_IP, v);
    check("R8 disabled pins count low", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c();
    logic [N-1:0] v;
    do_reset();
    wr(O_IN_EN, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0110;
    tick(4);
    wr(O_HIGH_IP, 32'h0000_0100);
    rd(O_HIGH_IP, v);
    check("R9 event beats clear", v, 32'h0000_0110);
    wr(O_RISE_IP, 32'h0);
    rd(O_RISE_IP, v);
    check("R9 zero write keeps bits", v, 32'h0000_0110);
    wr(O_RISE_IP, 32'h0000_0010);
    rd(O_RISE_IP, v);
    check("R9 partial clear", v, 32'h0000_0100);
  endtask

  task automatic t_irq();
    logic [N-1:0] v;
    do_reset();
    wr(O_IN_EN, 32'hFFFF_FFFF);
    tick(3);
    wr(O_RISE_IE, 32'h0000_0008);
    #1;
    check("R10 no irq without pending", irq, '0);
    pin_in = 32'h0000_0008;
    tick(3);
    check("R10 rise irq", irq, 32'h0000_0008);
    wr(O_LOW_IE, 32'h0010_0000);
    #1;
    check("R10 low irq adds", irq, 32'h0010_0008);
    wr(O_RISE_IE, 32'h0);
    wr(O_LOW_IE, 32'h0);
    #1;
    check("R10 irq gated by enable", irq, '0);
    rd(O_RISE_IP, v);
    check("R10 pending kept when disabled", v, 32'h0000_0008);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_outpath();
    t_alt();
    t_pad_cfg();
    t_input();
    t_edges();
    t_levels();
    t_w1c();
    t_irq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule